// File: doc/BRIEF.md
# Timestamp Event Status Unit

This block is the event side of a precision time unit. It receives the running 64-bit system time from a separate counter and watches four event sources: two asynchronous auxiliary inputs (a slave-side and a master-side snapshot request), a one-cycle target-time match strobe and a one-cycle pulse-per-second strobe. A rising edge on an auxiliary input copies the current time into that channel's 64-bit snapshot. Every source sets a sticky status bit. Software clears a status bit by writing 1 to it.

A small word-addressed register port exposes a control word that holds one interrupt enable per source, the status word and the two snapshots. Each snapshot is read as two 32-bit words, high word first. Reading the high word freezes the matching low word, so the two halves always come from the same capture. The interrupt output is a registered OR over all sources of status AND enable. The register port is a plain strobe interface with no back-pressure: a write takes effect at the clock edge where `bus_wr_i` is high, and read data appears on `bus_rdata_o` one cycle after `bus_rd_i`.

Top module: `tsu_event_unit`

## Requirements
- R1: After reset, the control word, the status word, both snapshots and the frozen low words read 0, and `irq_o` is 0.
- R2: A rising edge on `aux_slv_i` passes through two synchronizer flops and an edge detector. At the third clock edge after the input is first sampled high, status bit 2 is set and the slave snapshot takes the value of `time_i` at that edge. At the second clock edge the status bit is not yet set.
- R3: A rising edge on `aux_mst_i` behaves in the same way, using status bit 3 and the master snapshot. The slave snapshot is not changed.
- R4: An auxiliary input held high gives exactly one capture. A changing `time_i` while the input stays high does not alter the snapshot.
- R5: A high cycle on `tgt_hit_i` sets status bit 1. A high cycle on `pps_i` sets status bit 4.
- R6: A write to the status word (address 1) clears each status bit whose data bit is 1. Bits written with 0 are unchanged. Status bits 0 and 5 to 31 always read 0.
- R7: If a source event and a write-1 clear of the same bit fall in the same cycle, the bit ends up set.
- R8: A new capture on a channel whose status bit is still set overwrites the snapshot, and the bit stays set.
- R9: `irq_o` is 1 in the cycle after any status bit is set while its enable is set, and is 0 otherwise. The enables are control bits 1 (target), 2 (slave), 3 (master) and 4 (PPS).
- R10: Snapshot addresses: 2 is the slave high word, 3 the slave low word, 4 the master high word, 5 the master low word. A high-word read copies the channel's current low word into a hold register. A low-word read returns that hold register.
- R11: The control word (address 0) is written whole. It reads back only bits 1 to 4, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 64 | Current system time from the counter |
| aux_slv_i | input | 1 | Asynchronous slave-side snapshot request |
| aux_mst_i | input | 1 | Asynchronous master-side snapshot request |
| tgt_hit_i | input | 1 | One-cycle target-time match strobe |
| pps_i | input | 1 | One-cycle pulse-per-second strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, valid the cycle after `bus_rd_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Captures are tried with distinct time values that set different halves of the word. This shows whether the high and low words are routed correctly and whether the two channels are kept apart. A status read placed at the second edge after the input rises separates the proper two-flop synchronizer from a shallower one. A time change while the input is held high separates edge detection from level capture. Write-1-clear is driven with zero data, with data on other bits and with the matching bit, and once in the same cycle as a target strobe. A read of the high word followed by a recapture shows whether the low word was frozen. Interrupts are checked with the enable clear and then set, to confirm the masking.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int STAT_W    = 5;
  localparam int BIT_TGT   = 1;
  localparam int BIT_SLV   = 2;
  localparam int BIT_MST   = 3;
  localparam int BIT_PPS   = 4;
  localparam int N_CHAN    = 2;
  localparam int SNAP_BASE = 2;
  localparam logic [STAT_W-1:0] LIVE_MASK = 5'b11110;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_SLV_HI = 3'd2,
    A_SLV_LO = 3'd3,
    A_MST_HI = 3'd4,
    A_MST_LO = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tsu_edge_sync.sv
module tsu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
      last_q <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tsu_snap_chan.sv
module tsu_snap_chan #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              hi_rd_i,
  output logic [TIME_W-1:0] snap_o,
  output logic [TIME_W/2-1:0] lo_hold_o
);
  localparam int HALF = TIME_W / 2;

  logic [TIME_W-1:0] snap_q;
  logic [HALF-1:0]   hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
      hold_q <= '0;
    end else begin
      if (cap_i) snap_q <= time_i;
      // the hold sees the pre-capture value, matching the high word returned
      if (hi_rd_i) hold_q <= snap_q[HALF-1:0];
    end
  end

  assign snap_o    = snap_q;
  assign lo_hold_o = hold_q;
endmodule

// File: rtl/tsu_status.sv
module tsu_status #(
  parameter int              W    = 5,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= ((stat_q & ~clr_i) | set_i) & MASK;
      irq_q  <= |(stat_q & en_i);
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/tsu_event_unit.sv
module tsu_event_unit
  import tsu_pkg::*;
#(
  parameter int TIME_W      = 64,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  localparam int WORD_W     = TIME_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic              aux_slv_i,
  input  logic              aux_mst_i,
  input  logic              tgt_hit_i,
  input  logic              pps_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [N_CHAN-1:0] aux_in;
  logic [N_CHAN-1:0] rise;
  logic [N_CHAN-1:0] hi_rd;
  logic [TIME_W-1:0] snap_q  [N_CHAN];
  logic [WORD_W-1:0] lo_hold [N_CHAN];
  logic [STAT_W-1:0] en_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [WORD_W-1:0] rdata_q;

  assign aux_in = {aux_mst_i, aux_slv_i};

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    tsu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(aux_in[g]),
      .rise_o (rise[g])
    );

    assign hi_rd[g] = bus_rd_i && (bus_addr_i == ADDR_W'(SNAP_BASE + 2*g));

    tsu_snap_chan #(.TIME_W(TIME_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (rise[g]),
      .time_i   (time_i),
      .hi_rd_i  (hi_rd[g]),
      .snap_o   (snap_q[g]),
      .lo_hold_o(lo_hold[g])
    );
  end

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_TGT] = tgt_hit_i;
    set_vec[BIT_SLV] = rise[0];
    set_vec[BIT_MST] = rise[1];
    set_vec[BIT_PPS] = pps_i;
  end

  assign clr_vec = (bus_wr_i && bus_addr_i == ADDR_W'(A_STAT))
                   ? (bus_wdata_i[STAT_W-1:0] & LIVE_MASK) : '0;

  tsu_status #(.W(STAT_W), .MASK(LIVE_MASK)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .en_i  (en_q),
    .stat_o(stat_q),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (bus_wr_i && bus_addr_i == ADDR_W'(A_CTRL)) begin
      en_q <= bus_wdata_i[STAT_W-1:0] & LIVE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      case (bus_addr_i)
        ADDR_W'(A_CTRL):   rdata_q <= {{(WORD_W-STAT_W){1'b0}}, en_q};
        ADDR_W'(A_STAT):   rdata_q <= {{(WORD_W-STAT_W){1'b0}}, stat_q};
        ADDR_W'(A_SLV_HI): rdata_q <= snap_q[0][TIME_W-1:WORD_W];
        ADDR_W'(A_SLV_LO): rdata_q <= lo_hold[0];
        ADDR_W'(A_MST_HI): rdata_q <= snap_q[1][TIME_W-1:WORD_W];
        ADDR_W'(A_MST_LO): rdata_q <= lo_hold[1];
        default:           rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/tsu_event_chk.sv
module tsu_event_chk #(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIME_W-1:0] time_i,
  input logic              irq_o,
  input logic [1:0]        rise,
  input logic [4:0]        stat_q,
  input logic [4:0]        en_q,
  input logic [4:0]        set_vec,
  input logic [4:0]        clr_vec,
  input logic [TIME_W-1:0] snap_slv,
  input logic [TIME_W-1:0] snap_mst
);
  // R2
  slv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise[0] |=> (stat_q[2] && snap_slv == $past(time_i)));

  // R3
  mst_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise[1] |=> (stat_q[3] && snap_mst == $past(time_i) && $stable(snap_slv)));

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == 2'b00));

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((stat_q & $past(clr_vec & ~set_vec)) == 5'd0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ~clr_vec)) |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec)));

  // R9
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & en_q)) |=> irq_o);

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & en_q)) |=> !irq_o);
endmodule

bind tsu_event_unit tsu_event_chk #(.TIME_W(TIME_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .time_i  (time_i),
  .irq_o   (irq_o),
  .rise    (rise),
  .stat_q  (stat_q),
  .en_q    (en_q),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .snap_slv(snap_q[0]),
  .snap_mst(snap_q[1])
);

// File: tb/tsu_event_unit_bench.sv
module tsu_event_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_i = '0;
  logic        aux_slv_i = 1'b0;
  logic        aux_mst_i = 1'b0;
  logic        tgt_hit_i = 1'b0;
  logic        pps_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tsu_event_unit u_tsu_event_unit (
    .clk(clk), .rst_n(rst_n), .time_i(time_i),
    .aux_slv_i(aux_slv_i), .aux_mst_i(aux_mst_i),
    .tgt_hit_i(tgt_hit_i), .pps_i(pps_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic expect_reg(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic set_aux(int ch, logic v);
    if (ch == 0) aux_slv_i = v; else aux_mst_i = v;
  endtask

  // raise an auxiliary input; optionally confirm the status bit is still clear at the second edge
  task automatic raise_aux(string req, int ch, logic [31:0] early, logic [31:0] late, bit check_early);
    logic [31:0] d;
    @(negedge clk);
    set_aux(ch, 1'b1);
    @(negedge clk);
    bus_read(3'd1, d);
    if (check_early) check(req, d, early);
    expect_reg(req, 3'd1, late);
  endtask

  task automatic drop_aux(int ch);
    @(negedge clk);
    set_aux(ch, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    for (int a = 0; a < 6; a++) expect_reg("R1", 3'(a), 32'd0);
  endtask

  task automatic t_ctrl;
    bus_write(3'd0, 32'hFFFF_FFFF);
    expect_reg("R11", 3'd0, 32'h0000_001E);
    bus_write(3'd0, 32'h0000_0004);
    expect_reg("R11", 3'd0, 32'h0000_0004);
  endtask

  task automatic t_slave;
    time_i = 64'h1234_5678_9ABC_DEF0;
    raise_aux("R2", 0, 32'h0, 32'h4, 1'b1);
    check("R9 slave irq", {31'd0, irq_o}, 32'd1);
    time_i = 64'h0;
    repeat (4) @(negedge clk);
    expect_reg("R4 hi", 3'd2, 32'h1234_5678);
    expect_reg("R4 lo", 3'd3, 32'h9ABC_DEF0);
    expect_reg("R4 stat", 3'd1, 32'h4);
    drop_aux(0);
  endtask

  task automatic t_w1c;
    bus_write(3'd1, 32'h0);
    expect_reg("R6 zero", 3'd1, 32'h4);
    bus_write(3'd1, 32'hFFFF_FFEA);
    expect_reg("R6 other", 3'd1, 32'h4);
    bus_write(3'd1, 32'h4);
    expect_reg("R6 clear", 3'd1, 32'h0);
    check("R9 irq drop", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_master;
    bus_write(3'd0, 32'h0);
    time_i = 64'hCAFE_0001_0000_BEEF;
    raise_aux("R3", 1, 32'h0, 32'h8, 1'b1);
    drop_aux(1);
    check("R9 masked", {31'd0, irq_o}, 32'd0);
    expect_reg("R3 hi", 3'd4, 32'hCAFE_0001);
    expect_reg("R3 lo", 3'd5, 32'h0000_BEEF);
    expect_reg("R3 slave kept", 3'd2, 32'h1234_5678);
    bus_write(3'd0, 32'h8);
    repeat (2) @(negedge clk);
    check("R9 unmasked", {31'd0, irq_o}, 32'd1);
  endtask

  task automatic t_overwrite;
    time_i = 64'h0000_0002_1111_2222;
    raise_aux("R8", 1, 32'h8, 32'h8, 1'b0);
    drop_aux(1);
    expect_reg("R8 hi", 3'd4, 32'h0000_0002);
    expect_reg("R8 lo", 3'd5, 32'h1111_2222);
  endtask

  task automatic t_latch;
    expect_reg("R10 hi", 3'd4, 32'h0000_0002);
    time_i = 64'h0000_0003_3333_4444;
    raise_aux("R10", 1, 32'h8, 32'h8, 1'b0);
    drop_aux(1);
    expect_reg("R10 held lo", 3'd5, 32'h1111_2222);
    expect_reg("R10 new hi", 3'd4, 32'h0000_0003);
    expect_reg("R10 new lo", 3'd5, 32'h3333_4444);
  endtask

  task automatic t_tgt_pps;
    bus_write(3'd1, 32'h1E);
    bus_write(3'd0, 32'h12);
    expect_reg("R5 clear", 3'd1, 32'h0);
    check("R9 idle", {31'd0, irq_o}, 32'd0);
    @(negedge clk); tgt_hit_i = 1'b1;
    @(negedge clk); tgt_hit_i = 1'b0;
    expect_reg("R5 tgt", 3'd1, 32'h02);
    check("R9 tgt irq", {31'd0, irq_o}, 32'd1);
    @(negedge clk); pps_i = 1'b1;
    @(negedge clk); pps_i = 1'b0;
    expect_reg("R5 pps", 3'd1, 32'h12);
  endtask

  task automatic t_setclr;
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = 3'd1; bus_wdata_i = 32'h12; tgt_hit_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0; tgt_hit_i = 1'b0;
    expect_reg("R7", 3'd1, 32'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_slave();
    t_w1c();
    t_master();
    t_overwrite();
    t_latch();
    t_tgt_pps();
    t_setclr();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule